// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This engine carries block data between system memory and a card data port by walking a chain of descriptors. Each descriptor is four 32-bit words held in memory. The engine reads a descriptor and moves that descriptor's share of the remaining byte count. It then writes the status word back with the ownership flag cleared. It follows the next pointer until a descriptor flagged as last has been handled, or until the byte count is used up. When it finishes, it pulses completion bits into the raw interrupt status and the DMA status registers of a neighbouring interrupt block.

A transfer begins from a command-load pulse. The memory side is a word-wide request/grant port, and a request is held until it is granted. The card side is a byte stream with valid/ready handshakes, one stream for each direction. Each time a chunk of at most `CHUNK_BYTES` bytes has crossed the card port, the chunk's byte count is reported to the transfer-counter decrement input of the interrupt block.

Top module: `sdma_engine`

## Requirements
- R1: A start pulse is acted on only when the DMA enable input is high, the byte count and block size are both non-zero, and, for a card-to-memory transfer, the card reports data ready. Any other start pulse is ignored: busy stays low and no memory request is made.
- R2: A descriptor is fetched with four reads at its address plus 0, 4, 8 and 12, in that order. These words are status, buffer size, buffer address and next-descriptor address.
- R3: A buffer size of zero, or one larger than `MAX_DESC_BYTES`, is replaced by `MAX_DESC_BYTES`.
- R4: Each descriptor moves the smaller of its clamped size and the bytes still remaining.
- R5: Bits 1:0 of the buffer address are ignored. Data words are accessed at the aligned buffer address plus the word offset. Byte k of a descriptor travels in bits [8*(k mod 4)+7 : 8*(k mod 4)] of its word.
- R6: After a descriptor's data has moved, its status word is written back to the descriptor address with bit 31 (hold) cleared and all other bits unchanged.
- R7: The chain ends after a descriptor whose status bit 2 (last) is set, or once the remaining byte count reaches zero. Otherwise the next descriptor is fetched from the next-descriptor address.
- R8: Completion is a one-cycle pulse. It sets raw status bits 3 and 16, and DMA status bit 8 together with bit 0 for memory-to-card or bit 1 for card-to-memory.
- R9: A decrement pulse carries the byte count of each chunk. A chunk closes when it reaches `CHUNK_BYTES` bytes or when the last byte of a descriptor has crossed the card port.
- R10: A memory request, together with its address, direction and write data, stays stable until it is granted.
- R11: Card-to-memory bytes are packed into words. A word is written once it is full or the descriptor ends, and its unfilled upper lanes are written as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command-load pulse requesting a transfer |
| dir_wr_i | input | 1 | 1: memory to card, 0: card to memory |
| dma_en_i | input | 1 | DMA enable from global control |
| byte_count_i | input | CNT_W | Total bytes to transfer |
| block_size_i | input | CNT_W | Card block size (must be non-zero) |
| desc_base_i | input | ADDR_W | Address of the first descriptor |
| card_data_rdy_i | input | 1 | Card has read data available |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory grant; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Memory read data |
| card_tx_valid_o | output | 1 | Byte offered to card |
| card_tx_data_o | output | 8 | Byte to card |
| card_tx_ready_i | input | 1 | Card accepts byte |
| card_rx_valid_i | input | 1 | Card offers byte |
| card_rx_data_i | input | 8 | Byte from card |
| card_rx_ready_o | output | 1 | Engine accepts byte |
| xfer_dec_valid_o | output | 1 | Chunk decrement pulse |
| xfer_dec_bytes_o | output | CHUNK_W | Bytes in the chunk |
| raw_set_o | output | 32 | Raw interrupt status set pulse |
| dma_stat_set_o | output | 10 | DMA status set pulse |
| busy_o | output | 1 | Engine is running a chain |

## Verification
Most internal faults show up at the memory port within one access. A wrong remaining count or a wrong clamped length becomes visible when a descriptor ends: the writeback comes too early or too late, or the next fetch goes to the wrong address. A wrong byte lane or offset shows as a bad byte on the card stream, or a bad word written to memory, on the very beat concerned. A lost end-of-chain flag shows as an extra fetch a few cycles after the writeback. A broken chunk counter shows on the next decrement pulse.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_MRD, S_TX, S_RX, S_MWR, S_WB, S_DONE
  } sdma_state_e;

  localparam int ST_HOLD_BIT  = 31;
  localparam int ST_LAST_BIT  = 2;
  localparam int RAW_DATA_BIT = 3;
  localparam int RAW_DMA_BIT  = 16;
  localparam int DST_TX_BIT   = 0;
  localparam int DST_RX_BIT   = 1;
  localparam int DST_SUM_BIT  = 8;
endpackage

// File: rtl/sdma_len_clamp.sv
module sdma_len_clamp #(
  parameter int CNT_W     = 32,
  parameter int MAX_BYTES = 8192
) (
  input  logic [CNT_W-1:0] size_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] MaxL = CNT_W'(MAX_BYTES);
  logic [CNT_W-1:0] clamped;

  always_comb begin
    clamped = (size_i == '0 || size_i > MaxL) ? MaxL : size_i;
    len_o   = (rem_i < clamped) ? rem_i : clamped;
  end
endmodule

// File: rtl/sdma_chunk_cnt.sv
module sdma_chunk_cnt #(
  parameter int CHUNK_BYTES = 1024,
  localparam int CW = $clog2(CHUNK_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_i,
  input  logic          flush_i,
  output logic          dec_valid_o,
  output logic [CW-1:0] dec_bytes_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      dec_valid_o <= 1'b0;
      dec_bytes_o <= '0;
    end else begin
      dec_valid_o <= 1'b0;
      if (byte_i) begin
        if (cnt_nxt == CW'(CHUNK_BYTES) || flush_i) begin
          dec_valid_o <= 1'b1;
          dec_bytes_o <= cnt_nxt;
          cnt_q       <= '0;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 32,
  parameter int MAX_DESC_BYTES = 8192,
  parameter int CHUNK_BYTES    = 1024,
  localparam int CHUNK_W       = $clog2(CHUNK_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               dir_wr_i,
  input  logic               dma_en_i,
  input  logic [CNT_W-1:0]   byte_count_i,
  input  logic [CNT_W-1:0]   block_size_i,
  input  logic [ADDR_W-1:0]  desc_base_i,
  input  logic               card_data_rdy_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  input  logic               mem_gnt_i,
  input  logic [31:0]        mem_rdata_i,
  output logic               card_tx_valid_o,
  output logic [7:0]         card_tx_data_o,
  input  logic               card_tx_ready_i,
  input  logic               card_rx_valid_i,
  input  logic [7:0]         card_rx_data_i,
  output logic               card_rx_ready_o,
  output logic               xfer_dec_valid_o,
  output logic [CHUNK_W-1:0] xfer_dec_bytes_o,
  output logic [31:0]        raw_set_o,
  output logic [9:0]         dma_stat_set_o,
  output logic               busy_o
);
  import sdma_pkg::*;

  sdma_state_e        state_q;
  logic [1:0]         widx_q;
  logic [ADDR_W-1:0]  desc_addr_q;
  logic [31:0]        d_status_q;
  logic [CNT_W-1:0]   d_size_q;
  logic [ADDR_W-3:0]  d_buf_q;
  logic [ADDR_W-1:0]  d_next_q;
  logic [CNT_W-1:0]   rem_q;
  logic [CNT_W-1:0]   mv_len_q;
  logic [CNT_W-1:0]   off_q;
  logic [31:0]        word_q;
  logic               wr_dir_q;

  logic [CNT_W-1:0]   len_calc;
  logic [CNT_W-1:0]   off_inc;
  logic [CNT_W-1:0]   off_prev;
  logic [ADDR_W-1:0]  buf_base;
  logic [1:0]         lane;
  logic               tx_fire, rx_fire, last_byte, start_ok;

  sdma_len_clamp #(.CNT_W(CNT_W), .MAX_BYTES(MAX_DESC_BYTES)) u_clamp (
    .size_i(d_size_q), .rem_i(rem_q), .len_o(len_calc)
  );

  assign off_inc   = off_q + CNT_W'(1);
  assign off_prev  = off_q - CNT_W'(1);
  assign buf_base  = {d_buf_q, 2'b00};
  assign lane      = off_q[1:0];
  assign tx_fire   = (state_q == S_TX) && card_tx_ready_i;
  assign rx_fire   = (state_q == S_RX) && card_rx_valid_i;
  assign last_byte = (off_inc == mv_len_q);
  assign start_ok  = start_i && dma_en_i && byte_count_i != '0 && block_size_i != '0 &&
                     (dir_wr_i || card_data_rdy_i);

  sdma_chunk_cnt #(.CHUNK_BYTES(CHUNK_BYTES)) u_chunk (
    .clk_i, .rst_ni,
    .byte_i(tx_fire || rx_fire),
    .flush_i(last_byte),
    .dec_valid_o(xfer_dec_valid_o),
    .dec_bytes_o(xfer_dec_bytes_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr_q;
    mem_wdata_o = word_q;
    unique case (state_q)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr_q + ADDR_W'({widx_q, 2'b00});
      end
      S_MRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = buf_base + ADDR_W'({off_q[CNT_W-1:2], 2'b00});
      end
      S_MWR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = buf_base + ADDR_W'({off_prev[CNT_W-1:2], 2'b00});
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = d_status_q & ~(32'd1 << ST_HOLD_BIT);
      end
      default: ;
    endcase
  end

  assign card_tx_valid_o = (state_q == S_TX);
  assign card_tx_data_o  = word_q[{lane, 3'b000} +: 8];
  assign card_rx_ready_o = (state_q == S_RX);
  assign busy_o          = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      widx_q         <= '0;
      desc_addr_q    <= '0;
      d_status_q     <= '0;
      d_size_q       <= '0;
      d_buf_q        <= '0;
      d_next_q       <= '0;
      rem_q          <= '0;
      mv_len_q       <= '0;
      off_q          <= '0;
      word_q         <= '0;
      wr_dir_q       <= 1'b0;
      raw_set_o      <= '0;
      dma_stat_set_o <= '0;
    end else begin
      raw_set_o      <= '0;
      dma_stat_set_o <= '0;
      unique case (state_q)
        S_IDLE: if (start_ok) begin
          state_q     <= S_FETCH;
          widx_q      <= '0;
          desc_addr_q <= desc_base_i;
          rem_q       <= byte_count_i;
          wr_dir_q    <= dir_wr_i;
        end
        S_FETCH: if (mem_gnt_i) begin
          widx_q <= widx_q + 2'd1;
          unique case (widx_q)
            2'd0: d_status_q <= mem_rdata_i;
            2'd1: d_size_q   <= CNT_W'(mem_rdata_i);
            2'd2: d_buf_q    <= mem_rdata_i[ADDR_W-1:2];
            default: begin
              d_next_q <= ADDR_W'(mem_rdata_i);
              mv_len_q <= len_calc;
              off_q    <= '0;
              word_q   <= '0;
              state_q  <= wr_dir_q ? S_MRD : S_RX;
            end
          endcase
        end
        S_MRD: if (mem_gnt_i) begin
          word_q  <= mem_rdata_i;
          state_q <= S_TX;
        end
        S_TX: if (card_tx_ready_i) begin
          off_q <= off_inc;
          if (last_byte)           state_q <= S_WB;
          else if (lane == 2'd3)   state_q <= S_MRD;
        end
        S_RX: if (card_rx_valid_i) begin
          word_q[{lane, 3'b000} +: 8] <= card_rx_data_i;
          off_q <= off_inc;
          if (last_byte || lane == 2'd3) state_q <= S_MWR;
        end
        S_MWR: if (mem_gnt_i) begin
          word_q  <= '0;
          state_q <= (off_q == mv_len_q) ? S_WB : S_RX;
        end
        S_WB: if (mem_gnt_i) begin
          rem_q <= rem_q - mv_len_q;
          if (d_status_q[ST_LAST_BIT] || rem_q == mv_len_q) begin
            state_q <= S_DONE;
          end else begin
            desc_addr_q <= d_next_q;
            widx_q      <= '0;
            state_q     <= S_FETCH;
          end
        end
        S_DONE: begin
          raw_set_o[RAW_DATA_BIT]     <= 1'b1;
          raw_set_o[RAW_DMA_BIT]      <= 1'b1;
          dma_stat_set_o[DST_SUM_BIT] <= 1'b1;
          dma_stat_set_o[DST_TX_BIT]  <= wr_dir_q;
          dma_stat_set_o[DST_RX_BIT]  <= !wr_dir_q;
          state_q                     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 1024,
  localparam int CHUNK_W    = $clog2(CHUNK_BYTES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               mem_req_o,
  input logic               mem_gnt_i,
  input logic               mem_we_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [31:0]        mem_wdata_o,
  input logic               card_tx_valid_o,
  input logic               card_rx_ready_o,
  input logic               xfer_dec_valid_o,
  input logic [CHUNK_W-1:0] xfer_dec_bytes_o,
  input logic [31:0]        raw_set_o,
  input logic [9:0]         dma_stat_set_o
);
  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) &&
                               $stable(mem_we_o) && $stable(mem_wdata_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !card_tx_valid_o && !card_rx_ready_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_set_o != 32'd0) |=> (raw_set_o == 32'd0));

  // R8
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dma_stat_set_o[1:0]));

  // R8
  done_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_set_o != 32'd0) |-> dma_stat_set_o[8] && ($countones(dma_stat_set_o[1:0]) == 1));

  // R9
  chunk_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_dec_valid_o |-> (xfer_dec_bytes_o != '0) &&
                         (xfer_dec_bytes_o <= CHUNK_W'(CHUNK_BYTES)));

  // R5
  card_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_tx_valid_o && card_rx_ready_o));
endmodule

bind sdma_engine sdma_engine_chk #(
  .ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES)
) u_sdma_chk (.*);

// File: tb/sdma_engine_tb.sv
module sdma_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 32;
  localparam int CHB  = 8;
  localparam int CHW  = $clog2(CHB + 1);

  logic clk, rst_n;
  logic start, dir_wr, dma_en, card_rdy;
  logic [31:0] byte_count, block_size, desc_base;
  logic mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;
  logic dec_valid;
  logic [CHW-1:0] dec_bytes;
  logic [31:0] raw_set;
  logic [9:0] stat_set;
  logic busy;

  sdma_engine #(.MAX_DESC_BYTES(MAXB), .CHUNK_BYTES(CHB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_wr_i(dir_wr), .dma_en_i(dma_en),
    .byte_count_i(byte_count), .block_size_i(block_size), .desc_base_i(desc_base),
    .card_data_rdy_i(card_rdy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data),
    .card_tx_ready_i(tx_ready), .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data),
    .card_rx_ready_o(rx_ready), .xfer_dec_valid_o(dec_valid), .xfer_dec_bytes_o(dec_bytes),
    .raw_set_o(raw_set), .dma_stat_set_o(stat_set), .busy_o(busy)
  );

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; } acc_t;
  logic [31:0] mem [0:255];
  acc_t        exp_acc[$];
  logic [7:0]  exp_tx[$];
  int          exp_dec[$];
  logic [41:0] exp_done[$];
  logic [7:0]  rx_src[$];
  int checks = 0, fails = 0, cyc = 0;
  bit rx_pend = 0;
  int rx_seed = 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // drivers for memory/card plus scoreboard monitor, all at negedge
  always @(negedge clk) begin
    bit g;
    cyc++;
    g = (cyc % 3) != 0;
    if (rst_n && mem_req && g) begin
      if (exp_acc.size() == 0) chk(0, "R1 R7 unexpected memory access", mem_addr, 32'hx);
      else begin
        acc_t e;
        e = exp_acc.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr, "R2 R5 R6 R7 access addr/dir", {mem_we, mem_addr[30:0]}, {e.we, e.addr[30:0]});
        if (e.we) chk(mem_wdata == e.data, "R6 R11 write data", mem_wdata, e.data);
      end
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      else mem_rdata = mem[mem_addr[9:2]];
    end
    mem_gnt = g;
    tx_ready = (cyc % 4) != 1;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk(0, "R4 unexpected card byte", {24'd0, tx_data}, 32'hx);
      else begin
        logic [7:0] b;
        b = exp_tx.pop_front();
        chk(tx_data == b, "R5 card byte", {24'd0, tx_data}, {24'd0, b});
      end
    end
    if (rx_pend) void'(rx_src.pop_front());
    rx_valid = rx_src.size() > 0 && (cyc % 5) != 2;
    rx_data  = rx_valid ? rx_src[0] : 8'h00;
    rx_pend  = rx_valid && rx_ready;
    if (rst_n && dec_valid) begin
      if (exp_dec.size() == 0) chk(0, "R9 unexpected decrement", {28'd0, dec_bytes}, 32'hx);
      else begin
        int d;
        d = exp_dec.pop_front();
        chk(int'(dec_bytes) == d, "R9 chunk bytes", {28'd0, dec_bytes}, d);
      end
    end
    if (rst_n && raw_set != 0) begin
      if (exp_done.size() == 0) chk(0, "R8 unexpected completion", raw_set, 32'hx);
      else begin
        logic [41:0] d;
        d = exp_done.pop_front();
        chk(raw_set == d[41:10], "R8 raw status set", raw_set, d[41:10]);
        chk(stat_set == d[9:0], "R8 dma status set", {22'd0, stat_set}, {22'd0, d[9:0]});
      end
    end
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic put_desc(int a, logic [31:0] st, logic [31:0] sz, logic [31:0] bf, logic [31:0] nx);
    mem[a>>2] = st; mem[(a>>2)+1] = sz; mem[(a>>2)+2] = bf; mem[(a>>2)+3] = nx;
  endtask

  // reference walk of the chain from the requirements
  task automatic expect_chain(bit wr, int base, int bc);
    int addr = base, rem = bc, cc;
    forever begin
      logic [31:0] st, sz, bf, nx, w;
      int c, n, ab;
      for (int i = 0; i < 4; i++) exp_acc.push_back('{1'b0, 32'(addr + 4*i), 32'd0});
      st = mem[addr>>2]; sz = mem[(addr>>2)+1]; bf = mem[(addr>>2)+2]; nx = mem[(addr>>2)+3];
      c  = (sz == 0 || sz > MAXB) ? MAXB : int'(sz);  // R3
      n  = (c < rem) ? c : rem;                        // R4
      ab = int'(bf & 32'hFFFF_FFFC);                   // R5
      cc = 0; w = 0;
      for (int k = 0; k < n; k++) begin
        if (wr) begin
          if (k % 4 == 0) exp_acc.push_back('{1'b0, 32'(ab + k), 32'd0});
          exp_tx.push_back(8'(mem[(ab + k) >> 2] >> (8 * (k % 4))));
        end else begin
          logic [7:0] b;
          b = 8'(rx_seed * 37 + 11);
          rx_seed++;
          rx_src.push_back(b);
          w = w | (32'(b) << (8 * (k % 4)));
          if (k % 4 == 3 || k == n - 1) begin         // R11
            exp_acc.push_back('{1'b1, 32'(ab + (k & ~3)), w});
            w = 0;
          end
        end
        cc++;
        if (cc == CHB || k == n - 1) begin exp_dec.push_back(cc); cc = 0; end
      end
      exp_acc.push_back('{1'b1, 32'(addr), st & 32'h7FFF_FFFF});  // R6
      rem -= n;
      if (st[2] || rem == 0) break;                                  // R7
      addr = int'(nx);
    end
    exp_done.push_back({32'h0001_0008, wr ? 10'h101 : 10'h102});
  endtask

  task automatic pulse_start(bit wr, int base, int bc, bit en, int bs, bit rdy);
    @(negedge clk);
    dir_wr = wr; desc_base = base; byte_count = bc; dma_en = en; block_size = bs; card_rdy = rdy;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_chain(bit wr, int base, int bc);
    expect_chain(wr, base, bc);
    pulse_start(wr, base, bc, 1, 512, 1);
    while (busy || exp_done.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_acc.size() == 0, "R7 memory accesses outstanding", exp_acc.size(), 0);
    chk(exp_tx.size() == 0 && rx_src.size() == 0, "R4 card bytes outstanding", exp_tx.size() + rx_src.size(), 0);
    chk(exp_dec.size() == 0, "R9 decrements outstanding", exp_dec.size(), 0);
  endtask

  initial begin
    rst_n = 0; start = 0; dir_wr = 0; dma_en = 0; card_rdy = 0;
    byte_count = 0; block_size = 0; desc_base = 0;
    mem_gnt = 0; mem_rdata = 0; tx_ready = 0; rx_valid = 0; rx_data = 0;
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h0103_0507) ^ 32'hA5C3_1E00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req, "R1 reset idle", {busy, mem_req}, 0);
    chk(raw_set == 0 && stat_set == 0 && !dec_valid, "R8 reset no pulses", raw_set, 0);

    put_desc(32'h000, 32'h8000_000C, 10, 32'h102, 0);
    // R1 ignored starts
    pulse_start(1, 0, 10, 0, 512, 1);
    repeat (8) @(negedge clk);
    chk(!busy, "R1 dma disabled ignored", busy, 0);
    pulse_start(1, 0, 0, 1, 512, 1);
    repeat (8) @(negedge clk);
    chk(!busy, "R1 zero byte count ignored", busy, 0);
    pulse_start(1, 0, 10, 1, 0, 1);
    repeat (8) @(negedge clk);
    chk(!busy, "R1 zero block size ignored", busy, 0);
    pulse_start(0, 0, 10, 1, 512, 0);
    repeat (8) @(negedge clk);
    chk(!busy, "R1 read without card data ignored", busy, 0);

    // R5 unaligned buffer, R9 chunk split 8+2
    run_chain(1, 32'h000, 10);

    // R3 zero and oversize sizes, R4 remaining limit, R7 stop on count
    put_desc(32'h010, 32'h8000_0010, 0,   32'h200, 32'h020);
    put_desc(32'h020, 32'h8000_0018, 40,  32'h240, 32'h030);
    put_desc(32'h030, 32'h8000_0010, 100, 32'h280, 32'h000);
    run_chain(1, 32'h010, 70);

    // R7 last bit stops early, R11 partial word
    put_desc(32'h040, 32'h8000_0004, 6, 32'h300, 32'h050);
    put_desc(32'h050, 32'h8000_0004, 6, 32'h320, 32'h000);
    run_chain(0, 32'h040, 20);

    // R2 chained read, R5 unaligned read buffer
    put_desc(32'h060, 32'h8000_0018, 5, 32'h341, 32'h070);
    put_desc(32'h070, 32'h8000_0006, 9, 32'h380, 32'h000);
    run_chain(0, 32'h060, 14);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule